// File: doc/BRIEF.md
# Second-Operand Forwarding Select

This block steers the second ALU operand of a five-stage in-order integer pipeline. While an instruction sits in decode, the block works out which register that instruction will write. It then compares the instruction's rt field against the destinations of the two older instructions ahead of it. The resulting select code is captured in the decode/execute latch. In the next cycle it drives a four-way operand mux, whose inputs are the memory-stage result, the register-file rt value, the writeback-stage result and the immediate.

The comparison is made in decode against the destinations the older instructions carry now. These are the instructions that will occupy the memory and writeback stages when the current instruction reaches execute. A dependent chain therefore runs back to back without stalls. The block also carries the decoded destination down its own small shift chain (execute, memory, writeback), and that chain feeds the comparisons. A decode slot marked invalid enters the chain as a bubble that writes nothing. Register zero is never forwarded.

Top module: `fwd_ctl`

## Requirements
- R1: An instruction whose opcode (bits 31:26) is 0 is register-type, and its destination is its rd field (bits 15:11).
- R2: Stores (opcodes 0x28, 0x29, 0x2B), branches (opcodes 0x01, 0x04, 0x05, 0x06, 0x07) and the plain jump (opcode 0x02) have destination 0, whatever their rt field holds.
- R3: The jump-and-link (opcode 0x03) has destination 31.
- R4: Every other opcode takes its destination from the rt field (bits 20:16).
- R5: A valid instruction that is not register-type gets select 3 (immediate).
- R6: For a valid register-type instruction, select 0 (memory-stage bypass) is chosen when its rt equals the destination currently held at `ex_dst`. That instruction is the one heading to the memory stage. When `ex_dst` and `me_dst` both match, this choice wins.
- R7: Select 2 (writeback-stage bypass) is chosen when rt equals `me_dst` and does not equal `ex_dst`.
- R8: A register number of 0 never matches. A valid register-type instruction with no match gets select 1 (register-file value).
- R9: The select and the destination appear on `ex_sel` and `ex_dst` on the clock edge after the instruction is presented. The destination then moves to `me_dst` and `wb_dst` on each of the following edges.
- R10: When `id_valid` is low, a bubble is latched with destination 0 and select 1.
- R11: While reset is asserted, `ex_sel` is 1 and all three destination outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | Decode slot holds a live instruction |
| id_insn | input | 32 | Instruction word in decode |
| ex_sel | output | 2 | Latched operand select: 0 memory bypass, 1 register value, 2 writeback bypass, 3 immediate |
| ex_dst | output | 5 | Destination of the instruction in execute |
| me_dst | output | 5 | Destination of the instruction in memory |
| wb_dst | output | 5 | Destination of the instruction in writeback |

## Verification
The bench feeds a dependent chain in which each consumer needs the producer one or two slots older. A design that compared against the wrong stage would choose the writeback bypass where the memory bypass was needed, and the check would show it. A run of two writers of the same register tests that the younger one wins; a reversed priority would forward a stale value. Writes to register 0 and reads of register 0 test that r0 never matches, since a design without the zero rule would forward a garbage value. A branch with a nonzero rt field, followed by a consumer of that rt, exposes a decoder that treats branches as rt writers. A bubble followed by a consumer shows whether an invalid slot leaks a destination into the chain.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [1:0] {
    SEL_ME_BYP = 2'd0,
    SEL_RT_REG = 2'd1,
    SEL_WB_BYP = 2'd2,
    SEL_IMM    = 2'd3
  } opnd_sel_e;

  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_RTYPE  = 6'h00;
  localparam logic [OPC_W-1:0] OPC_REGIMM = 6'h01;
  localparam logic [OPC_W-1:0] OPC_JMP    = 6'h02;
  localparam logic [OPC_W-1:0] OPC_JLINK  = 6'h03;
  localparam logic [OPC_W-1:0] OPC_BEQ    = 6'h04;
  localparam logic [OPC_W-1:0] OPC_BNE    = 6'h05;
  localparam logic [OPC_W-1:0] OPC_BLEZ   = 6'h06;
  localparam logic [OPC_W-1:0] OPC_BGTZ   = 6'h07;
  localparam logic [OPC_W-1:0] OPC_SB     = 6'h28;
  localparam logic [OPC_W-1:0] OPC_SH     = 6'h29;
  localparam logic [OPC_W-1:0] OPC_SW     = 6'h2B;

endpackage

// File: rtl/dst_decode.sv
module dst_decode
  import fwd_pkg::*;
#(
  parameter int RA_W = 5
) (
  input  logic                 valid,
  input  logic [OPC_W-1:0]     opc,
  input  logic [RA_W-1:0]      rt,
  input  logic [RA_W-1:0]      rd,
  output logic                 is_rtype,
  output logic [RA_W-1:0]      dst
);

  localparam logic [RA_W-1:0] LINK_REG = '1;

  logic writes_none;
  logic is_link;

  always_comb begin
    is_rtype = (opc == OPC_RTYPE);
    is_link  = (opc == OPC_JLINK);
    unique case (opc)
      OPC_REGIMM, OPC_BEQ, OPC_BNE, OPC_BLEZ, OPC_BGTZ,
      OPC_SB, OPC_SH, OPC_SW, OPC_JMP: writes_none = 1'b1;
      default:                          writes_none = 1'b0;
    endcase
  end

  always_comb begin
    if (!valid || writes_none) dst = '0;
    else if (is_rtype)         dst = rd;
    else if (is_link)          dst = LINK_REG;
    else                       dst = rt;
  end

endmodule

// File: rtl/reg_match.sv
module reg_match #(
  parameter int RA_W = 5
) (
  input  logic [RA_W-1:0] a,
  input  logic [RA_W-1:0] b,
  output logic            hit
);

  always_comb hit = (a == b) && (a != '0);

endmodule

// File: rtl/opnd_sel_gen.sv
module opnd_sel_gen
  import fwd_pkg::*;
#(
  parameter int RA_W  = 5,
  parameter int N_CMP = 2
) (
  input  logic                       valid,
  input  logic                       is_rtype,
  input  logic [RA_W-1:0]            rt,
  input  logic [N_CMP-1:0][RA_W-1:0] older_dst,
  output opnd_sel_e                  sel
);

  logic [N_CMP-1:0] hit;

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    reg_match #(.RA_W(RA_W)) u_match (
      .a  (rt),
      .b  (older_dst[g]),
      .hit(hit[g])
    );
  end

  always_comb begin
    if (!valid)         sel = SEL_RT_REG;
    else if (!is_rtype) sel = SEL_IMM;
    else if (hit[0])    sel = SEL_ME_BYP;
    else if (hit[1])    sel = SEL_WB_BYP;
    else                sel = SEL_RT_REG;
  end

endmodule

// File: rtl/fwd_ctl.sv
module fwd_ctl
  import fwd_pkg::*;
#(
  parameter int INSN_W = 32,
  parameter int RA_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_valid,
  input  logic [INSN_W-1:0] id_insn,
  output logic [1:0]        ex_sel,
  output logic [RA_W-1:0]   ex_dst,
  output logic [RA_W-1:0]   me_dst,
  output logic [RA_W-1:0]   wb_dst
);

  localparam int OPC_LSB = INSN_W - OPC_W;
  localparam int RT_LSB  = OPC_LSB - 2*RA_W;
  localparam int RD_LSB  = RT_LSB - RA_W;
  localparam int NSTG    = 3;

  logic [OPC_W-1:0] opc;
  logic [RA_W-1:0]  rt, rd, id_dst;
  logic             is_rtype;
  opnd_sel_e        id_sel;
  logic [NSTG-1:0][RA_W-1:0] dst_q;
  opnd_sel_e        sel_q;

  assign opc = id_insn[OPC_LSB +: OPC_W];
  assign rt  = id_insn[RT_LSB  +: RA_W];
  assign rd  = id_insn[RD_LSB  +: RA_W];

  logic unused_fields;
  assign unused_fields = ^{id_insn[RT_LSB+RA_W +: RA_W], id_insn[RD_LSB-1:0]};

  dst_decode #(.RA_W(RA_W)) u_dec (
    .valid   (id_valid),
    .opc     (opc),
    .rt      (rt),
    .rd      (rd),
    .is_rtype(is_rtype),
    .dst     (id_dst)
  );

  opnd_sel_gen #(.RA_W(RA_W), .N_CMP(2)) u_sel (
    .valid    (id_valid),
    .is_rtype (is_rtype),
    .rt       (rt),
    .older_dst({dst_q[1], dst_q[0]}),
    .sel      (id_sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= SEL_RT_REG;
    else        sel_q <= id_sel;
  end

  for (genvar g = 0; g < NSTG; g++) begin : g_dst
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dst_q[g] <= '0;
      else if (g == 0) dst_q[g] <= id_dst;
      else             dst_q[g] <= dst_q[(g == 0) ? 0 : g-1];
    end
  end

  assign ex_sel = sel_q;
  assign ex_dst = dst_q[0];
  assign me_dst = dst_q[1];
  assign wb_dst = dst_q[2];

endmodule

// File: rtl/fwd_ctl_chk.sv
module fwd_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        id_valid,
  input logic [31:0] id_insn,
  input logic [1:0]  ex_sel,
  input logic [4:0]  ex_dst,
  input logic [4:0]  me_dst,
  input logic [4:0]  wb_dst
);

  p_chain_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (me_dst == $past(ex_dst)) && (wb_dst == $past(me_dst)));

  p_imm_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(id_valid) && $past(id_insn[31:26]) != 6'h00) |-> ex_sel == 2'd3);

  p_me_byp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ex_sel == 2'd0) |-> (me_dst != 5'd0) && ($past(id_insn[20:16]) == me_dst));

  p_wb_byp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ex_sel == 2'd2) |->
      (wb_dst != 5'd0) && ($past(id_insn[20:16]) == wb_dst) && ($past(id_insn[20:16]) != me_dst));

  p_link_dst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(id_valid) && $past(id_insn[31:26]) == 6'h03) |-> ex_dst == 5'd31);

  p_bubble_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(id_valid)) |-> (ex_dst == 5'd0) && (ex_sel == 2'd1));

endmodule

bind fwd_ctl fwd_ctl_chk u_chk (.*);

// File: tb/fwd_ctl_bench.sv
module fwd_ctl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        id_valid = 1'b0;
  logic [31:0] id_insn = '0;
  logic [1:0]  ex_sel;
  logic [4:0]  ex_dst, me_dst, wb_dst;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  fwd_ctl u_fwd_ctl (.*);

  function automatic logic [31:0] mk_r(int rs, int rt, int rd);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, 6'h20};
  endfunction
  function automatic logic [31:0] mk_i(int op, int rs, int rt);
    return {op[5:0], rs[4:0], rt[4:0], 16'h0004};
  endfunction
  function automatic logic [31:0] mk_j(int op);
    return {op[5:0], 26'h0000040};
  endfunction

  typedef struct packed {
    logic [31:0] insn;
    logic [1:0]  sel;
    logic [4:0]  dst;
  } vec_t;

  localparam int NV = 21;
  // sel: 0 ME bypass, 1 register, 2 WB bypass, 3 immediate
  localparam vec_t VEC [NV] = '{
    '{mk_r(2, 3, 1),     2'd1, 5'd1 },  // R1 R8 nothing older
    '{mk_r(5, 1, 4),     2'd0, 5'd4 },  // R6 producer one slot ahead
    '{mk_r(8, 1, 6),     2'd2, 5'd6 },  // R7 producer two slots ahead
    '{mk_r(11, 4, 9),    2'd2, 5'd9 },  // R7 chain continues
    '{mk_r(2, 3, 7),     2'd1, 5'd7 },  // R8 no match
    '{mk_r(2, 3, 7),     2'd1, 5'd7 },  // second writer of r7
    '{mk_r(2, 7, 10),    2'd0, 5'd10},  // R6 both match, younger wins
    '{mk_r(2, 3, 0),     2'd1, 5'd0 },  // R1 write to r0
    '{mk_r(2, 0, 5),     2'd1, 5'd5 },  // R8 r0 never forwarded
    '{mk_i(6'h23, 2, 12),2'd3, 5'd12},  // R4 R5 load
    '{mk_r(2, 12, 13),   2'd0, 5'd13},  // R6
    '{mk_i(6'h2B, 2, 13),2'd3, 5'd0 },  // R2 store
    '{mk_r(2, 13, 14),   2'd2, 5'd14},  // R7 store is no writer
    '{mk_i(6'h04, 14,14),2'd3, 5'd0 },  // R2 branch
    '{mk_j(6'h03),       2'd3, 5'd31},  // R3 link
    '{mk_r(2, 31, 1),    2'd0, 5'd1 },  // R6 link reg forwarded
    '{mk_j(6'h02),       2'd3, 5'd0 },  // R2 plain jump
    '{mk_i(6'h08, 1, 3), 2'd3, 5'd3 },  // R4 immediate op
    '{mk_r(2, 3, 15),    2'd0, 5'd15},  // R6
    '{mk_i(6'h01, 3, 1), 2'd3, 5'd0 },  // R2 branch with rt=1
    '{mk_r(2, 1, 16),    2'd1, 5'd16}   // R2 R8 branch rt did not leak
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] insn);
    id_valid = v;
    id_insn  = insn;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 sel", ex_sel, 1);
    chk("R11 ex_dst", ex_dst, 0);
    chk("R11 me_dst", me_dst, 0);
    chk("R11 wb_dst", wb_dst, 0);
    rst_n = 1'b1;
    @(negedge clk);

    begin
      logic [4:0] d1, d2;
      d1 = 5'd0;
      d2 = 5'd0;
      for (int i = 0; i < NV; i++) begin
        step(1'b1, VEC[i].insn);
        chk($sformatf("R5-R8 sel row %0d", i), ex_sel, VEC[i].sel);
        chk($sformatf("R1-R4 dst row %0d", i), ex_dst, VEC[i].dst);
        chk("R9 me_dst shift", me_dst, d1);
        chk("R9 wb_dst shift", wb_dst, d2);
        d2 = d1;
        d1 = VEC[i].dst;
      end
    end

    // R10 bubble leaves no destination
    step(1'b1, mk_r(2, 3, 20));
    step(1'b0, mk_r(2, 3, 22));
    chk("R10 bubble dst", ex_dst, 0);
    chk("R10 bubble sel", ex_sel, 1);
    step(1'b1, mk_r(2, 20, 21));
    chk("R10 R7 past bubble", ex_sel, 2);
    step(1'b1, mk_r(2, 22, 23));
    chk("R10 bubble rd not forwarded", ex_sel, 1);

    // R9 drain: destination reaches writeback two edges later
    step(1'b0, '0);
    chk("R9 me_dst", me_dst, 23);
    step(1'b0, '0);
    chk("R9 wb_dst", wb_dst, 23);

    // R11 async reset mid-stream
    id_valid = 1'b1;
    id_insn  = mk_j(6'h03);
    @(posedge clk);
    #2 rst_n = 1'b0;
    #1;
    chk("R11 async ex_dst", ex_dst, 0);
    chk("R11 async sel", ex_sel, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule